// File: doc/BRIEF.md
# I2C Controller Status and Interrupt Flags

This block holds the status word of an I2C controller peripheral. The bus engine reports events to it as single-cycle strobes: a byte transfer finished, the slave address matched, a general call arrived, a start or stop condition was seen, arbitration was lost, the R/W bit of the calling address, and the sampled acknowledge level. The CPU side reports its register accesses as strobes too: a data-register read, a data-register write, a control-register write and a status-register write with its data. A level shows whether the controller is transmitting or receiving.

Each flag has its own set and clear sources. The transfer-complete flag is cleared by the data-register access that suits the current direction. The addressed flag is cleared by any control write. The arbitration and interrupt flags are cleared by writing 1 to them. The interrupt-pending flag gathers three events. A level interrupt request is driven from it, gated by an enable input. All state is registered and uses a synchronous active-high reset.

Top module: `i2c_status_flags`

## Requirements
- R1: After reset, `status` is 8'h00 and `irq` is 0.
- R2: `status[7]` (transfer complete) is set the cycle after `ev_byte_done`. It is cleared the cycle after `cpu_data_rd` while `tx_mode`=0, or the cycle after `cpu_data_wr` while `tx_mode`=1. A data read in transmit mode or a data write in receive mode leaves it unchanged.
- R3: `status[6]` (addressed as slave) is set by `ev_addr_match`, or by `ev_gcall` while `gcall_en`=1, and is cleared by `cpu_ctrl_wr`. A general call with `gcall_en`=0 has no effect on any bit.
- R4: `status[5]` (bus busy) is set the cycle after `ev_start` and cleared the cycle after `ev_stop`.
- R5: `status[4]` (arbitration lost) is set by `ev_arb_lost` and is cleared only by `cpu_stat_wr` with `cpu_wdata[4]`=1. A status write with `cpu_wdata[4]`=0 leaves it unchanged.
- R6: `status[2]` (slave read/write) loads `ev_rw_bit` only on an accepted address event (an address match, or a general call with `gcall_en`=1). 1 means slave transmit and 0 means slave receive.
- R7: `status[1]` (interrupt pending) is set by `ev_byte_done`, by an accepted address event or by `ev_arb_lost`. It is cleared by `cpu_stat_wr` with `cpu_wdata[1]`=1.
- R8: `status[0]` (received acknowledge) loads `ev_ack_level` (0 = ACK seen, 1 = no ACK) only on `ev_ack_sample`. At other times it holds its value.
- R9: When a set event and a clear strobe for the same flag come in the same cycle, the flag ends up set. This holds for a start and a stop in the same cycle.
- R10: `status[3]` always reads 0, and `irq` equals `status[1]` AND `irq_en` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_byte_done | input | 1 | Byte transfer finished (pulse) |
| ev_addr_match | input | 1 | Calling address matched own slave address (pulse) |
| ev_gcall | input | 1 | General-call address received (pulse) |
| gcall_en | input | 1 | Accept general calls |
| ev_start | input | 1 | Start condition seen on the bus (pulse) |
| ev_stop | input | 1 | Stop condition seen on the bus (pulse) |
| ev_arb_lost | input | 1 | Arbitration lost (pulse) |
| ev_rw_bit | input | 1 | R/W bit of the calling address, valid with an address event |
| ev_ack_sample | input | 1 | Acknowledge slot sampled (pulse) |
| ev_ack_level | input | 1 | Sampled acknowledge level, 0 = ACK |
| cpu_data_rd | input | 1 | Data register read (pulse) |
| cpu_data_wr | input | 1 | Data register write (pulse) |
| cpu_ctrl_wr | input | 1 | Control register write (pulse) |
| cpu_stat_wr | input | 1 | Status register write (pulse) |
| cpu_wdata | input | 8 | Write data that comes with a status write |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| irq_en | input | 1 | Interrupt enable |
| status | output | 8 | Status word |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest cases to reach are collisions in a single cycle: a set event together with the clear strobe for the same flag, and a data access whose direction does not match the current mode. Both must leave a flag set when a naive design would clear it. The stimulus table builds these cases on purpose. It sets a flag, tries the access in the wrong mode, and then fires the set and the clear together. Status writes whose other bits are all 1 while the relevant clear bit is 0 show that write-1-to-clear looks only at its own bit.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    localparam int STAT_W   = 8;
    localparam int POS_TC   = 7;
    localparam int POS_AAS  = 6;
    localparam int POS_BUSY = 5;
    localparam int POS_ARB  = 4;
    localparam int POS_RSVD = 3;
    localparam int POS_SRW  = 2;
    localparam int POS_IP   = 1;
    localparam int POS_RXAK = 0;

    // sticky flags handled by the generic set/clear cell
    localparam int N_STICKY = 5;
    localparam int SK_TC    = 0;
    localparam int SK_AAS   = 1;
    localparam int SK_BUSY  = 2;
    localparam int SK_ARB   = 3;
    localparam int SK_IP    = 4;

    localparam logic [STAT_W-1:0] W1C_MASK = (STAT_W'(1) << POS_ARB) | (STAT_W'(1) << POS_IP);

    typedef struct packed {
        logic byte_done;
        logic addr_match;
        logic gcall;
        logic gcall_en;
        logic start;
        logic stop;
        logic arb_lost;
        logic rw_bit;
        logic ack_sample;
        logic ack_level;
    } bus_ev_t;

    typedef struct packed {
        logic                data_rd;
        logic                data_wr;
        logic                ctrl_wr;
        logic                stat_wr;
        logic [STAT_W-1:0]   wdata;
        logic                tx_mode;
    } cpu_acc_t;

    typedef struct packed {
        logic tc;
        logic aas;
        logic busy;
        logic arb;
        logic rsvd;
        logic srw;
        logic ip;
        logic rxak;
    } stat_t;

    function automatic logic w1c_hit(input logic [STAT_W-1:0] wdata, input int pos);
        logic [STAT_W-1:0] masked;
        masked = wdata & W1C_MASK;
        return masked[pos];
    endfunction

endpackage

// File: rtl/i2c_flag_cell.sv
module i2c_flag_cell #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_r;

    // set has priority over clear
    always_ff @(posedge clk) begin
        if (rst)        q_r <= RESET_VAL;
        else if (set_i) q_r <= 1'b1;
        else if (clr_i) q_r <= 1'b0;
    end

    assign q_o = q_r;

    assert_set_priority_R9: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o);
    assert_clear_only_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/i2c_capture_bit.sv
module i2c_capture_bit #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic d_i,
    output logic q_o
);
    logic q_r;

    always_ff @(posedge clk) begin
        if (rst)         q_r <= RESET_VAL;
        else if (load_i) q_r <= d_i;
    end

    assign q_o = q_r;

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(q_o));
endmodule

// File: rtl/i2c_stat_set_dec.sv
module i2c_stat_set_dec
    import i2c_stat_pkg::*;
(
    input  bus_ev_t               ev_i,
    output logic [N_STICKY-1:0]   set_o,
    output logic                  addr_hit_o
);
    logic addr_hit;

    always_comb begin
        addr_hit = ev_i.addr_match | (ev_i.gcall & ev_i.gcall_en);
        set_o             = '0;
        set_o[SK_TC]      = ev_i.byte_done;
        set_o[SK_AAS]     = addr_hit;
        set_o[SK_BUSY]    = ev_i.start;
        set_o[SK_ARB]     = ev_i.arb_lost;
        set_o[SK_IP]      = ev_i.byte_done | addr_hit | ev_i.arb_lost;
    end

    assign addr_hit_o = addr_hit;
endmodule

// File: rtl/i2c_stat_clr_dec.sv
module i2c_stat_clr_dec
    import i2c_stat_pkg::*;
(
    input  cpu_acc_t              acc_i,
    input  logic                  stop_i,
    output logic [N_STICKY-1:0]   clr_o
);
    always_comb begin
        clr_o           = '0;
        clr_o[SK_TC]    = (acc_i.data_rd & ~acc_i.tx_mode) | (acc_i.data_wr & acc_i.tx_mode);
        clr_o[SK_AAS]   = acc_i.ctrl_wr;
        clr_o[SK_BUSY]  = stop_i;
        clr_o[SK_ARB]   = acc_i.stat_wr & w1c_hit(acc_i.wdata, POS_ARB);
        clr_o[SK_IP]    = acc_i.stat_wr & w1c_hit(acc_i.wdata, POS_IP);
    end
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
    import i2c_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_byte_done,
    input  logic              ev_addr_match,
    input  logic              ev_gcall,
    input  logic              gcall_en,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_arb_lost,
    input  logic              ev_rw_bit,
    input  logic              ev_ack_sample,
    input  logic              ev_ack_level,
    input  logic              cpu_data_rd,
    input  logic              cpu_data_wr,
    input  logic              cpu_ctrl_wr,
    input  logic              cpu_stat_wr,
    input  logic [7:0]        cpu_wdata,
    input  logic              tx_mode,
    input  logic              irq_en,
    output logic [7:0]        status,
    output logic              irq
);
    bus_ev_t              ev;
    cpu_acc_t             acc;
    logic [N_STICKY-1:0]  set_v;
    logic [N_STICKY-1:0]  clr_v;
    logic [N_STICKY-1:0]  flag_q;
    logic                 addr_hit;
    logic                 srw_q;
    logic                 rxak_q;
    stat_t                word;

    always_comb begin
        ev.byte_done  = ev_byte_done;
        ev.addr_match = ev_addr_match;
        ev.gcall      = ev_gcall;
        ev.gcall_en   = gcall_en;
        ev.start      = ev_start;
        ev.stop       = ev_stop;
        ev.arb_lost   = ev_arb_lost;
        ev.rw_bit     = ev_rw_bit;
        ev.ack_sample = ev_ack_sample;
        ev.ack_level  = ev_ack_level;
        acc.data_rd   = cpu_data_rd;
        acc.data_wr   = cpu_data_wr;
        acc.ctrl_wr   = cpu_ctrl_wr;
        acc.stat_wr   = cpu_stat_wr;
        acc.wdata     = cpu_wdata;
        acc.tx_mode   = tx_mode;
    end

    i2c_stat_set_dec u_set (
        .ev_i       (ev),
        .set_o      (set_v),
        .addr_hit_o (addr_hit)
    );

    i2c_stat_clr_dec u_clr (
        .acc_i  (acc),
        .stop_i (ev.stop),
        .clr_o  (clr_v)
    );

    for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
        i2c_flag_cell #(.RESET_VAL(1'b0)) u_cell (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_v[g]),
            .clr_i (clr_v[g]),
            .q_o   (flag_q[g])
        );
    end

    i2c_capture_bit #(.RESET_VAL(1'b0)) u_srw (
        .clk    (clk),
        .rst    (rst),
        .load_i (addr_hit),
        .d_i    (ev.rw_bit),
        .q_o    (srw_q)
    );

    i2c_capture_bit #(.RESET_VAL(1'b0)) u_rxak (
        .clk    (clk),
        .rst    (rst),
        .load_i (ev.ack_sample),
        .d_i    (ev.ack_level),
        .q_o    (rxak_q)
    );

    always_comb begin
        word.tc   = flag_q[SK_TC];
        word.aas  = flag_q[SK_AAS];
        word.busy = flag_q[SK_BUSY];
        word.arb  = flag_q[SK_ARB];
        word.rsvd = 1'b0;
        word.srw  = srw_q;
        word.ip   = flag_q[SK_IP];
        word.rxak = rxak_q;
    end

    assign status = word;
    assign irq    = word.ip & irq_en;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (status == 8'h00));
    assert_tc_set_R2: assert property (@(posedge clk) disable iff (rst)
        ev_byte_done |=> status[POS_TC]);
    assert_gcall_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (ev_gcall && !gcall_en && !ev_addr_match && !cpu_ctrl_wr) |=> (status[POS_AAS] == $past(status[POS_AAS])));
    assert_busy_stop_R4: assert property (@(posedge clk) disable iff (rst)
        (ev_stop && !ev_start) |=> !status[POS_BUSY]);
    assert_arb_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (status[POS_ARB] && !(cpu_stat_wr && cpu_wdata[POS_ARB])) |=> status[POS_ARB]);
    assert_srw_load_R6: assert property (@(posedge clk) disable iff (rst)
        ev_addr_match |=> (status[POS_SRW] == $past(ev_rw_bit)));
    assert_ip_set_R7: assert property (@(posedge clk) disable iff (rst)
        (ev_byte_done || ev_arb_lost || ev_addr_match) |=> status[POS_IP]);
    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !status[POS_RSVD]);
endmodule

// File: tb/tb_i2c_status_flags.sv
module tb_i2c_status_flags;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_byte_done = 0, ev_addr_match = 0, ev_gcall = 0, gcall_en = 0;
    logic ev_start = 0, ev_stop = 0, ev_arb_lost = 0, ev_rw_bit = 0;
    logic ev_ack_sample = 0, ev_ack_level = 0;
    logic cpu_data_rd = 0, cpu_data_wr = 0, cpu_ctrl_wr = 0, cpu_stat_wr = 0;
    logic [7:0] cpu_wdata = 8'h00;
    logic tx_mode = 0, irq_en = 1;
    logic [7:0] status;
    logic irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    i2c_status_flags dut (
        .clk(clk), .rst(rst),
        .ev_byte_done(ev_byte_done), .ev_addr_match(ev_addr_match),
        .ev_gcall(ev_gcall), .gcall_en(gcall_en),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_arb_lost(ev_arb_lost),
        .ev_rw_bit(ev_rw_bit), .ev_ack_sample(ev_ack_sample), .ev_ack_level(ev_ack_level),
        .cpu_data_rd(cpu_data_rd), .cpu_data_wr(cpu_data_wr),
        .cpu_ctrl_wr(cpu_ctrl_wr), .cpu_stat_wr(cpu_stat_wr),
        .cpu_wdata(cpu_wdata), .tx_mode(tx_mode), .irq_en(irq_en),
        .status(status), .irq(irq)
    );

    // stimulus bit positions
    localparam logic [14:0] S_BYTE = 15'h0001;
    localparam logic [14:0] S_ADDR = 15'h0002;
    localparam logic [14:0] S_GC   = 15'h0004;
    localparam logic [14:0] S_GCEN = 15'h0008;
    localparam logic [14:0] S_STA  = 15'h0010;
    localparam logic [14:0] S_STO  = 15'h0020;
    localparam logic [14:0] S_ARB  = 15'h0040;
    localparam logic [14:0] S_RW   = 15'h0080;
    localparam logic [14:0] S_AKS  = 15'h0100;
    localparam logic [14:0] S_AKL  = 15'h0200;
    localparam logic [14:0] S_DRD  = 15'h0400;
    localparam logic [14:0] S_DWR  = 15'h0800;
    localparam logic [14:0] S_CWR  = 15'h1000;
    localparam logic [14:0] S_SWR  = 15'h2000;
    localparam logic [14:0] S_TX   = 15'h4000;

    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  wdata;
        logic [14:0] stim;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t TBL [NV] = '{
        '{4'd4,  8'h00, S_STA,                 8'h20},
        '{4'd2,  8'h00, S_BYTE,                8'hA2},
        '{4'd2,  8'h00, S_DWR,                 8'hA2},
        '{4'd2,  8'h00, S_DRD,                 8'h22},
        '{4'd7,  8'h02, S_SWR,                 8'h20},
        '{4'd3,  8'h00, S_GC | S_RW,           8'h20},
        '{4'd6,  8'h00, S_ADDR | S_RW,         8'h66},
        '{4'd6,  8'h00, 15'h0000,              8'h66},
        '{4'd3,  8'h00, S_CWR,                 8'h26},
        '{4'd6,  8'h00, S_GC | S_GCEN,         8'h62},
        '{4'd7,  8'h02, S_SWR,                 8'h60},
        '{4'd8,  8'h00, S_AKS | S_AKL,         8'h61},
        '{4'd8,  8'h00, 15'h0000,              8'h61},
        '{4'd8,  8'h00, S_AKS,                 8'h60},
        '{4'd5,  8'h00, S_ARB,                 8'h72},
        '{4'd5,  8'hED, S_SWR,                 8'h72},
        '{4'd5,  8'h10, S_SWR,                 8'h62},
        '{4'd9,  8'h00, S_BYTE | S_DWR | S_TX, 8'hE2},
        '{4'd2,  8'h00, S_DRD | S_TX,          8'hE2},
        '{4'd2,  8'h00, S_DWR | S_TX,          8'h62},
        '{4'd9,  8'h12, S_ARB | S_SWR,         8'h72},
        '{4'd9,  8'h00, S_ADDR | S_RW | S_CWR, 8'h76},
        '{4'd4,  8'h00, S_STO,                 8'h56},
        '{4'd9,  8'h00, S_STA | S_STO,         8'h76},
        '{4'd4,  8'h00, S_STO,                 8'h56},
        '{4'd7,  8'h12, S_SWR,                 8'h44}
    };

    task automatic drive(input logic [14:0] s, input logic [7:0] wd);
        ev_byte_done  = s[0];  ev_addr_match = s[1];  ev_gcall    = s[2];
        gcall_en      = s[3];  ev_start      = s[4];  ev_stop     = s[5];
        ev_arb_lost   = s[6];  ev_rw_bit     = s[7];  ev_ack_sample = s[8];
        ev_ack_level  = s[9];  cpu_data_rd   = s[10]; cpu_data_wr = s[11];
        cpu_ctrl_wr   = s[12]; cpu_stat_wr   = s[13]; tx_mode     = s[14];
        cpu_wdata     = wd;
    endtask

    // one cycle of stimulus, returns with outputs settled after the edge
    task automatic step(input logic [14:0] s, input logic [7:0] wd);
        @(negedge clk);
        drive(s, wd);
        @(posedge clk);
        #1;
        drive(15'h0000, 8'h00);
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check8("R1", status, 8'h00);
        check1("R1", irq, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            step(TBL[i].stim, TBL[i].wdata);
            tag = $sformatf("R%0d row %0d", TBL[i].req, i);
            check8(tag, status, TBL[i].exp);
            // R10: irq follows pending with enable high
            check1("R10", irq, TBL[i].exp[1]);
        end

        // R10: enable gating of the request (pending is 0 here)
        step(S_BYTE, 8'h00);
        check1("R10 pending set", status[1], 1'b1);
        @(negedge clk);
        irq_en = 1'b0;
        #1;
        check1("R10 irq masked", irq, 1'b0);
        @(negedge clk);
        irq_en = 1'b1;
        #1;
        check1("R10 irq unmasked", irq, 1'b1);
        // R10: reserved bit cannot be written
        step(S_SWR, 8'h08);
        check1("R10 reserved", status[3], 1'b0);
        // R7: clear pending drops irq
        step(S_SWR, 8'h02);
        check1("R7 irq cleared", irq, 1'b0);

        // R1: reset with flags set
        step(S_ARB | S_STA | S_AKS | S_AKL | S_ADDR | S_RW, 8'h00);
        check8("R1 pre-reset", status, 8'hF7);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check8("R1 mid reset", status, 8'h00);
        check1("R1 irq", irq, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule